// File: doc/BRIEF.md
# Configuration Space Host Port Decoder

This block sits on the host I/O path and turns accesses to two fixed port locations into configuration cycles on one local bus. A 32-bit selector register lives at I/O port 0x0CF8. Software writes into it an enable bit, a bus number, a device/function number and a dword-aligned register offset. It then reads or writes through a four-byte data window at ports 0x0CFC to 0x0CFF, and the decoder forwards each access as a single-cycle request to the selected function.

The decoder only forwards an access when the enable bit is set, the bus number is zero, and the selected device/function is marked present. Absent or undecoded targets read back as all-ones. Writes aimed at the fixed identification and status bytes of the configuration header are dropped before they reach the function. A presence map holds one bit per device/function and is loaded as a whole through a side input. Every access to a decoder port is answered one clock later with an acknowledge and its read data.

Top module: `cfgd_host_decoder`

## Requirements
- R1: A dword write (io_size = 2) to port 0x0CF8 stores all 32 bits into the selector, and a dword read of 0x0CF8 returns the last value stored.
- R2: A write to port 0x0CF8 with any size other than dword leaves the selector unchanged. A read of it with size 0 (1 byte) or 1 (2 bytes) returns 0xFF or 0xFFFF respectively.
- R3: A data-window access is forwarded only when selector bit 31 is 1 and selector bits 23:16 are all zero.
- R4: On a forwarded access, cfg_devfn carries selector bits 15:8, with the device in bits 15:11 and the function in bits 10:8.
- R5: On a forwarded access, cfg_reg equals selector bits 7:2 followed by the low two bits of the data-window port.
- R6: A data-window read that is not forwarded returns all-ones over its size: 0xFF for size 0, 0xFFFF for size 1, 0xFFFFFFFF for size 2. Size 3 is reserved; it is never forwarded and reads as 0xFFFFFFFF. This covers a failed decode, an absent function and the reserved size.
- R7: A data-window write is forwarded only when cfg_reg is 4 to 7, 12, 13, or 15 and above. Writes to offsets 0 to 3, 8 to 11 and 14 produce no request.
- R8: A forwarded read returns cfg_rdata masked to its size, taking the low 1, 2 or 4 bytes. Every write acknowledge carries zero read data.
- R9: Reset clears the selector and the presence map. A pulse on map_load replaces the whole map, where bit n marks device/function n present.
- R10: io_ack is high in exactly the cycle after an io_req to port 0x0CF8 or 0x0CFC to 0x0CFF, and low after any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_req | input | 1 | Host I/O access strobe, one cycle per access |
| io_wr | input | 1 | 1 for write, 0 for read |
| io_port | input | 16 | I/O port address |
| io_size | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| io_wdata | input | 32 | Write data, right-justified |
| io_ack | output | 1 | Access answered (one cycle after request) |
| io_rdata | output | 32 | Read data, right-justified |
| map_load | input | 1 | Load presence map |
| map_data | input | DEV_COUNT*8 | New presence map, bit per device/function |
| cfg_req | output | 1 | Configuration request to a function |
| cfg_wr | output | 1 | Request is a write |
| cfg_devfn | output | 8 | Target device/function |
| cfg_reg | output | 8 | Target byte offset |
| cfg_size | output | 2 | Access size, same coding as io_size |
| cfg_wdata | output | 32 | Write data to the function |
| cfg_rdata | input | 32 | Right-justified read data from the function, same cycle |

## Verification
The assertions assume that io_req is a single-cycle strobe and that the function answers cfg_rdata combinationally in the request cycle. They also assume the map and the selector are not changed in the same cycle as a data-window access. The stimulus drives each access for one clock and gives each access its own cycle. The bench models the function as a pure combinational pattern of cfg_devfn and cfg_reg. It reloads the presence map only between accesses, so every expected value is fixed when the request is issued.

// File: rtl/cfgd_pkg.sv
package cfgd_pkg;

  localparam int DATA_W = 32;
  localparam int PORT_W = 16;
  localparam int DEVFN_W = 8;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_DWORD = 2'd2,
    SZ_RSVD  = 2'd3
  } io_size_e;

  localparam logic [PORT_W-1:0] SEL_PORT  = 16'h0CF8;
  localparam logic [PORT_W-3:0] WIN_PORT  = 14'h033F;

  // lanes that carry data for a given access size
  function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: lane_mask = 32'h0000_00FF;
      SZ_WORD: lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  endfunction

endpackage

// File: rtl/cfgd_sel_reg.sv
module cfgd_sel_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_val,
  output logic [W-1:0] sel_q
);
  logic [W-1:0] sel_d;

  always_comb begin
    sel_d = sel_q;
    if (wr_en) sel_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= '0;
    else        sel_q <= sel_d;
  end
endmodule

// File: rtl/cfgd_presence.sv
module cfgd_presence #(
  parameter int SLOTS = 256,
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SLOTS-1:0] load_map,
  input  logic [IDX_W-1:0] idx,
  output logic             present
);
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  logic [SLOTS-1:0] map_q;
  logic [SLOTS-1:0] map_d;

  always_comb begin
    map_d = map_q;
    if (load) map_d = load_map;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) map_q <= '0;
    else        map_q <= map_d;
  end

  generate
    if (SLOTS >= (1 << IDX_W)) begin : g_full
      assign present = map_q[idx];
    end else begin : g_partial
      logic in_range;
      assign in_range = ({24'd0, idx} < SLOTS);
      assign present  = in_range & map_q[idx[SW-1:0]];
    end
  endgenerate
endmodule

// File: rtl/cfgd_wr_filter.sv
module cfgd_wr_filter (
  input  logic [7:0] off,
  output logic       allow
);
  logic blk_id;
  logic blk_mid;
  logic blk_14;

  always_comb begin
    blk_id  = (off < 8'd4);
    blk_mid = (off >= 8'd8) && (off <= 8'd11);
    blk_14  = (off == 8'd14);
    allow   = !(blk_id || blk_mid || blk_14);
  end
endmodule

// File: rtl/cfgd_rsp_reg.sv
module cfgd_rsp_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ack_d,
  input  logic [W-1:0] data_d,
  output logic         ack_q,
  output logic [W-1:0] data_q
);
  logic [W-1:0] data_nx;

  always_comb begin
    data_nx = data_q;
    if (ack_d) data_nx = data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q  <= 1'b0;
      data_q <= '0;
    end else begin
      ack_q  <= ack_d;
      data_q <= data_nx;
    end
  end
endmodule

// File: rtl/cfgd_host_decoder.sv
module cfgd_host_decoder
  import cfgd_pkg::*;
#(
  parameter int DEV_COUNT = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   io_req,
  input  logic                   io_wr,
  input  logic [15:0]            io_port,
  input  logic [1:0]             io_size,
  input  logic [31:0]            io_wdata,
  output logic                   io_ack,
  output logic [31:0]            io_rdata,
  input  logic                   map_load,
  input  logic [DEV_COUNT*8-1:0] map_data,
  output logic                   cfg_req,
  output logic                   cfg_wr,
  output logic [7:0]             cfg_devfn,
  output logic [7:0]             cfg_reg,
  output logic [1:0]             cfg_size,
  output logic [31:0]            cfg_wdata,
  input  logic [31:0]            cfg_rdata
);
  localparam int FN_PER_DEV = 8;
  localparam int SLOTS      = DEV_COUNT * FN_PER_DEV;
  localparam int EN_BIT     = DATA_W - 1;
  localparam int BUS_LO     = 16;
  localparam int BUS_HI     = 23;

  logic [DATA_W-1:0] addr_q;
  logic              on_sel;
  logic              on_win;
  logic              sel_wr_en;
  logic              decode_ok;
  logic              size_ok;
  logic              fn_present;
  logic              wr_allow;
  logic [7:0]        devfn;
  logic [7:0]        reg_off;
  logic [DATA_W-1:0] mask;
  logic              fwd;
  logic              hit;
  logic [DATA_W-1:0] rsp_data;

  // port decode
  always_comb begin
    on_sel    = (io_port == SEL_PORT);
    on_win    = (io_port[PORT_W-1:2] == WIN_PORT);
    hit       = io_req && (on_sel || on_win);
    sel_wr_en = io_req && io_wr && on_sel && (io_size == SZ_DWORD);
  end

  cfgd_sel_reg #(.W(DATA_W)) u_sel (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (sel_wr_en),
    .wr_val (io_wdata),
    .sel_q  (addr_q)
  );

  // selector field extraction
  always_comb begin
    decode_ok = addr_q[EN_BIT] && (addr_q[BUS_HI:BUS_LO] == '0);
    devfn     = addr_q[15:8];
    reg_off   = {addr_q[7:2], io_port[1:0]};
    size_ok   = (io_size != SZ_RSVD);
    mask      = lane_mask(io_size);
  end

  cfgd_presence #(.SLOTS(SLOTS), .IDX_W(DEVFN_W)) u_pres (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (map_load),
    .load_map (map_data),
    .idx      (devfn),
    .present  (fn_present)
  );

  cfgd_wr_filter u_filt (
    .off   (reg_off),
    .allow (wr_allow)
  );

  // request toward the functions
  always_comb begin
    fwd       = io_req && on_win && decode_ok && fn_present && size_ok &&
                (!io_wr || wr_allow);
    cfg_req   = fwd;
    cfg_wr    = io_wr;
    cfg_devfn = devfn;
    cfg_reg   = reg_off;
    cfg_size  = io_size;
    cfg_wdata = io_wdata;
  end

  // response data
  always_comb begin
    if (io_wr)
      rsp_data = '0;
    else if (on_sel)
      rsp_data = (io_size == SZ_DWORD) ? addr_q : mask;
    else if (fwd)
      rsp_data = cfg_rdata & mask;
    else
      rsp_data = mask;
  end

  cfgd_rsp_reg #(.W(DATA_W)) u_rsp (
    .clk    (clk),
    .rst_n  (rst_n),
    .ack_d  (hit),
    .data_d (rsp_data),
    .ack_q  (io_ack),
    .data_q (io_rdata)
  );
endmodule

// File: rtl/cfgd_checker.sv
module cfgd_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        io_req,
  input logic        io_wr,
  input logic [15:0] io_port,
  input logic [1:0]  io_size,
  input logic        io_ack,
  input logic        cfg_req,
  input logic        cfg_wr,
  input logic [7:0]  cfg_reg,
  input logic [31:0] addr_q
);
  logic port_hit;
  assign port_hit = io_req && ((io_port == 16'h0CF8) ||
                    (io_port >= 16'h0CFC && io_port <= 16'h0CFF));

  assert_ack_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    port_hit |=> io_ack);

  assert_no_stray_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !port_hit |=> !io_ack);

  assert_ro_dropped_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_req && cfg_wr) |-> !((cfg_reg <= 8'd3) || (cfg_reg inside {[8'd8:8'd11]}) ||
                              (cfg_reg == 8'd14)));

  assert_lane_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (io_req && cfg_reg[1:0] == io_port[1:0]));

  assert_bus0_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_req |-> (addr_q[31] && addr_q[23:16] == 8'd0));

  assert_narrow_sel_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (io_req && io_wr && io_port == 16'h0CF8 && io_size != 2'd2) |=> $stable(addr_q));
endmodule

bind cfgd_host_decoder cfgd_checker u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .io_req  (io_req),
  .io_wr   (io_wr),
  .io_port (io_port),
  .io_size (io_size),
  .io_ack  (io_ack),
  .cfg_req (cfg_req),
  .cfg_wr  (cfg_wr),
  .cfg_reg (cfg_reg),
  .addr_q  (addr_q)
);

// File: tb/sim_cfgd_host_decoder.sv
module sim_cfgd_host_decoder;
  localparam int DEVS = 32;
  localparam logic [15:0] P_SEL = 16'h0CF8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             io_req, io_wr;
  logic [15:0]      io_port;
  logic [1:0]       io_size;
  logic [31:0]      io_wdata;
  logic             io_ack;
  logic [31:0]      io_rdata;
  logic             map_load;
  logic [DEVS*8-1:0] map_data;
  logic             cfg_req, cfg_wr;
  logic [7:0]       cfg_devfn, cfg_reg;
  logic [1:0]       cfg_size;
  logic [31:0]      cfg_wdata, cfg_rdata;

  int n_chk = 0;
  int n_bad = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  // function model: combinational pattern of devfn and offset
  function automatic logic [31:0] fnv(input logic [7:0] df, input logic [7:0] rg);
    return {rg, df, ~rg, 8'h5A};
  endfunction
  function automatic logic [31:0] msk(input logic [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  assign cfg_rdata = fnv(cfg_devfn, cfg_reg);

  cfgd_host_decoder #(.DEV_COUNT(DEVS)) u0 (
    .clk(clk), .rst_n(rst_n), .io_req(io_req), .io_wr(io_wr), .io_port(io_port),
    .io_size(io_size), .io_wdata(io_wdata), .io_ack(io_ack), .io_rdata(io_rdata),
    .map_load(map_load), .map_data(map_data), .cfg_req(cfg_req), .cfg_wr(cfg_wr),
    .cfg_devfn(cfg_devfn), .cfg_reg(cfg_reg), .cfg_size(cfg_size),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // monitor: pops scoreboard on each acknowledge
  always @(negedge clk) begin
    if (rst_n && io_ack) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected ack", 32'd1, 32'd0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(io_rdata === e, t, io_rdata, e);
      end
    end
  end

  // driver: one access, pushes expectation, checks the forwarded request
  task automatic io(input bit wr, input logic [15:0] port, input logic [1:0] sz,
                    input logic [31:0] wd, input logic [31:0] exp_rd,
                    input bit exp_fwd, input logic [7:0] exp_df,
                    input logic [7:0] exp_rg, input string tag);
    automatic bit hit = (port == P_SEL) || (port[15:2] == 14'h033F);
    @(negedge clk);
    io_req = 1'b1; io_wr = wr; io_port = port; io_size = sz; io_wdata = wd;
    if (hit) begin
      exp_q.push_back(exp_rd);
      tag_q.push_back(tag);
    end
    #1;
    check(cfg_req === exp_fwd, {tag, " fwd"}, {31'd0, cfg_req}, {31'd0, exp_fwd});
    if (exp_fwd) begin
      check(cfg_devfn === exp_df, "R4 devfn", {24'd0, cfg_devfn}, {24'd0, exp_df});
      check(cfg_reg === exp_rg, "R5 offset", {24'd0, cfg_reg}, {24'd0, exp_rg});
    end
    @(negedge clk);
    io_req = 1'b0; io_wr = 1'b0;
    if (!hit) check(io_ack === 1'b0, "R10 no ack off-port", {31'd0, io_ack}, 32'd0);
  endtask

  task automatic sel_wr(input logic [31:0] v);
    io(1'b1, P_SEL, 2'd2, v, 32'd0, 1'b0, 8'd0, 8'd0, "R1 sel write");
  endtask

  task automatic load_map(input logic [DEVS*8-1:0] m);
    @(negedge clk);
    map_load = 1'b1; map_data = m;
    @(negedge clk);
    map_load = 1'b0;
  endtask

  initial begin
    #400000;
    check(1'b0, "watchdog", 32'd0, 32'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_req = 1'b0; io_wr = 1'b0; io_port = '0; io_size = '0;
    io_wdata = '0; map_load = 1'b0; map_data = '0;
    repeat (3) @(negedge clk);
    check(io_ack === 1'b0, "R9 reset ack", {31'd0, io_ack}, 32'd0);
    rst_n = 1'b1;

    // R9: selector cleared by reset
    io(1'b0, P_SEL, 2'd2, 0, 32'd0, 1'b0, 0, 0, "R9 sel after reset");

    // R9: map empty after reset -> function at devfn 08 absent
    sel_wr(32'h8000_0810);
    io(1'b0, 16'h0CFC, 2'd2, 0, 32'hFFFF_FFFF, 1'b0, 0, 0, "R9 map clear");

    map_data = '0;
    load_map((256'd1 << 8) | (256'd1 << 8'h11));

    // R1 readback
    io(1'b0, P_SEL, 2'd2, 0, 32'h8000_0810, 1'b0, 0, 0, "R1 sel readback");
    // R2 narrow access
    io(1'b1, P_SEL, 2'd0, 32'h12, 32'd0, 1'b0, 0, 0, "R2 narrow write ack");
    io(1'b1, P_SEL, 2'd1, 32'h1234, 32'd0, 1'b0, 0, 0, "R2 word write ack");
    io(1'b0, P_SEL, 2'd2, 0, 32'h8000_0810, 1'b0, 0, 0, "R2 sel unchanged");
    io(1'b0, P_SEL, 2'd0, 0, 32'hFF, 1'b0, 0, 0, "R2 byte read ones");
    io(1'b0, P_SEL, 2'd1, 0, 32'hFFFF, 1'b0, 0, 0, "R2 word read ones");

    // R4 R5 R8 forwarded reads
    io(1'b0, 16'h0CFC, 2'd2, 0, fnv(8'h08, 8'h10), 1'b1, 8'h08, 8'h10, "R8 dword read");
    io(1'b0, 16'h0CFE, 2'd0, 0, fnv(8'h08, 8'h12) & 32'hFF, 1'b1, 8'h08, 8'h12, "R8 byte read");
    io(1'b0, 16'h0CFD, 2'd1, 0, fnv(8'h08, 8'h11) & 32'hFFFF, 1'b1, 8'h08, 8'h11, "R8 word read");
    sel_wr(32'h8000_1124);
    io(1'b0, 16'h0CFF, 2'd0, 0, fnv(8'h11, 8'h27) & 32'hFF, 1'b1, 8'h11, 8'h27, "R5 lane 3 read");

    // R6 absent function and reserved size
    sel_wr(32'h8000_0910);
    io(1'b0, 16'h0CFC, 2'd2, 0, 32'hFFFF_FFFF, 1'b0, 0, 0, "R6 absent dword");
    io(1'b0, 16'h0CFD, 2'd0, 0, 32'hFF, 1'b0, 0, 0, "R6 absent byte");
    sel_wr(32'h8000_0810);
    io(1'b0, 16'h0CFC, 2'd3, 0, 32'hFFFF_FFFF, 1'b0, 0, 0, "R6 reserved size");

    // R3 decode condition
    sel_wr(32'h0000_0810);
    io(1'b0, 16'h0CFC, 2'd2, 0, 32'hFFFF_FFFF, 1'b0, 0, 0, "R3 enable clear");
    sel_wr(32'h8001_0810);
    io(1'b0, 16'h0CFC, 2'd1, 0, 32'hFFFF, 1'b0, 0, 0, "R3 bus nonzero");
    io(1'b1, 16'h0CFC, 2'd2, 32'h1, 32'd0, 1'b0, 0, 0, "R3 bus nonzero write");

    // R7 write filter
    sel_wr(32'h8000_0800);
    io(1'b1, 16'h0CFC, 2'd2, 32'hAA, 32'd0, 1'b0, 0, 0, "R7 offset 0 dropped");
    io(1'b1, 16'h0CFF, 2'd0, 32'hAA, 32'd0, 1'b0, 0, 0, "R7 offset 3 dropped");
    sel_wr(32'h8000_0804);
    io(1'b1, 16'h0CFC, 2'd2, 32'hBB, 32'd0, 1'b1, 8'h08, 8'h04, "R7 offset 4 passed");
    io(1'b1, 16'h0CFF, 2'd0, 32'hBB, 32'd0, 1'b1, 8'h08, 8'h07, "R7 offset 7 passed");
    sel_wr(32'h8000_0808);
    io(1'b1, 16'h0CFC, 2'd2, 32'hCC, 32'd0, 1'b0, 0, 0, "R7 offset 8 dropped");
    io(1'b1, 16'h0CFF, 2'd0, 32'hCC, 32'd0, 1'b0, 0, 0, "R7 offset 11 dropped");
    sel_wr(32'h8000_080C);
    io(1'b1, 16'h0CFC, 2'd0, 32'hDD, 32'd0, 1'b1, 8'h08, 8'h0C, "R7 offset 12 passed");
    io(1'b1, 16'h0CFD, 2'd0, 32'hDD, 32'd0, 1'b1, 8'h08, 8'h0D, "R7 offset 13 passed");
    io(1'b1, 16'h0CFE, 2'd0, 32'hDD, 32'd0, 1'b0, 0, 0, "R7 offset 14 dropped");
    io(1'b1, 16'h0CFF, 2'd0, 32'hDD, 32'd0, 1'b1, 8'h08, 8'h0F, "R7 offset 15 passed");
    // read of a protected offset still forwarded
    io(1'b0, 16'h0CFE, 2'd0, 0, fnv(8'h08, 8'h0E) & 32'hFF, 1'b1, 8'h08, 8'h0E, "R7 offset 14 read");

    // R9 reload of map removes devfn 08
    load_map(256'd1 << 8'h11);
    io(1'b0, 16'h0CFC, 2'd2, 0, 32'hFFFF_FFFF, 1'b0, 0, 0, "R9 map reload");

    // R10 off-port access, then back-to-back hits
    io(1'b0, 16'h0080, 2'd0, 0, 32'd0, 1'b0, 0, 0, "R10 off-port");
    io(1'b1, 16'h0CF9, 2'd2, 32'h5, 32'd0, 1'b0, 0, 0, "R10 CF9 off-port");
    io(1'b0, P_SEL, 2'd2, 0, 32'h8000_080C, 1'b0, 0, 0, "R10 sel read");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R10 pending ack", exp_q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule